// File: doc/BRIEF.md
# Two-Step Reload Watchdog

This block is a watchdog timer clocked from an always-on slow clock (nominally 32 kHz). A free-running prescaler divides that clock by a parameterised modulus (512 by default), and each prescaler wrap decrements an 8-bit down counter while the watchdog is armed. If firmware lets the counter run out, the block raises a one-cycle reset request and falls back to its power-on state.

Firmware reaches the block through two write ports and two read values: a control register, with an arm bit and a reload-permit bit, and a count register. Reloading takes two steps. Firmware first sets the reload-permit bit, then writes the new count. The permit bit clears itself after any accepted count write, so a stray write cannot keep a failing program alive. A count write of zero while reloads are permitted disarms the watchdog, and this is the only software path that disarms it. Each accepted count write restarts the prescaler, so the interval after a reload is always a whole number of ticks.

Top module: `wdog_interlock`

## Requirements
- R1: After the synchronous reset, the status output reads 00h, the count reads 00h and the reset request is low.
- R2: A control write with data bit 1 set arms the watchdog. A control write cannot disarm it. Data bit 0 of every control write is copied into the reload-permit flag. The status output shows the arm flag on bit 1 and the permit flag on bit 0, and all other status bits read 0.
- R3: The prescaler counts from 0 to PRE_TC and wraps. On each wrap the count decrements by one if the watchdog is armed. While the watchdog is disarmed, the count holds.
- R4: When a nonzero value N is accepted while the watchdog is armed, the reset request rises exactly N*(PRE_TC+1) cycles after the accepting edge. If the watchdog is armed with a count of 00h, it expires at the next prescaler wrap.
- R5: Any count write accepted while the permit flag is set clears the permit flag.
- R6: A count write of 00h while the permit flag is set clears the arm flag, the permit flag and the count.
- R7: A count write while the permit flag is clear is ignored. The count, the prescaler phase and both flags stay unchanged.
- R8: Every accepted count write restarts the prescaler from 0, so a reload in the middle of a tick restarts the full interval.
- R9: The reset request lasts exactly one cycle. In that same cycle the block is back in its power-on state: disarmed, permit clear, count 00h, prescaler at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit 1 arm, bit 0 reload permit) |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count write data |
| status | output | 8 | Control/status read value |
| count | output | 8 | Current count |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Every cycle, the assertions check the local rules: the permit flag clears itself after an accepted write, a zero write disarms, ignored writes and a disarmed watchdog leave the count unchanged, the prescaler stays in range and restarts on loads, and the reset request is a single-cycle pulse that coincides with the power-on state. Only the bench scenarios can show the exact interval between a reload and the reset request, the restart of that interval on a mid-tick reload, the expiry of an armed zero count at the next wrap, and the absence of any request after a disarm.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W        = 8;
  localparam int CTL_PERMIT_B = 0;
  localparam int CTL_ARM_B    = 1;

  typedef struct packed {
    logic arm;
    logic permit;
  } wdog_ctl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W  = 9,
  parameter int PRE_TC = 511
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam logic [PRE_W-1:0] TC = PRE_W'(PRE_TC);

  logic [PRE_W-1:0] phase;

  assign tick = (phase == TC);

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else if (tick)      phase <= '0;
    else                phase <= phase + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= TC);                                               // R3
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == '0));                                 // R8
endmodule

// File: rtl/wdog_ctlregs.sv
module wdog_ctlregs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             expire,
  output wdog_ctl_t        ctl,
  output logic             accept,
  output logic             load,
  output logic             disarm
);
  assign accept = cnt_wr && ctl.permit;
  assign disarm = accept && (cnt_wdata == '0);
  assign load   = accept && (cnt_wdata != '0);

  always_ff @(posedge clk) begin
    if (rst || expire || disarm)             ctl.arm <= 1'b0;
    else if (ctrl_wr && ctrl_wdata[CTL_ARM_B]) ctl.arm <= 1'b1;

    if (rst || expire || accept) ctl.permit <= 1'b0;
    else if (ctrl_wr)            ctl.permit <= ctrl_wdata[CTL_PERMIT_B];
  end

  AST_PERMIT_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ctl.permit);                                    // R5
  AST_ZERO_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && ctl.permit && cnt_wdata == '0) |=> !ctl.arm);    // R6
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctl.arm && !expire && !disarm) |=> ctl.arm);               // R2
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tick,
  input  logic             load,
  input  logic             disarm,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = arm && tick && !load && !disarm && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || expire || disarm) count <= '0;
    else if (load)               count <= load_val;
    else if (arm && tick)        count <= count - 1'b1;
  end

  AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!arm && !load && !disarm) |=> $stable(count));             // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (arm && tick && !load && !disarm && count > CNT_W'(1))
      |=> (count == $past(count) - 1'b1));                      // R3
endmodule

// File: rtl/wdog_interlock.sv
module wdog_interlock
  import wdog_pkg::*;
#(
  parameter int PRE_W  = 9,
  parameter int PRE_TC = 511
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       cnt_wr,
  input  logic [7:0] cnt_wdata,
  output logic [7:0] status,
  output logic [7:0] count,
  output logic       rst_req
);
  wdog_ctl_t        ctl;
  logic             accept, load, disarm, tick, expire;
  logic [CNT_W-1:0] cnt_q;

  wdog_ctlregs u_regs (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .expire(expire),
    .ctl(ctl), .accept(accept), .load(load), .disarm(disarm)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .PRE_TC(PRE_TC)) u_pre (
    .clk(clk), .rst(rst), .restart(accept || expire), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst(rst), .arm(ctl.arm), .tick(tick), .load(load),
    .disarm(disarm), .load_val(cnt_wdata), .count(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= expire;
  end

  always_comb begin
    status               = '0;
    status[CTL_ARM_B]    = ctl.arm;
    status[CTL_PERMIT_B] = ctl.permit;
  end
  assign count = cnt_q;

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !ctl.permit && !ctl.arm && !ctrl_wr)
      |=> ($stable(count) && $stable(status)));                 // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);                                      // R9
  AST_POR_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (count == 8'h00 && status == 8'h00));           // R9
endmodule

// File: tb/wdog_interlock_tb.sv
module wdog_interlock_tb;
  localparam int TC = 7;
  localparam int P  = TC + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0, cnt_wdata = '0;
  logic [7:0] status, count;
  logic       rst_req;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_interlock #(.PRE_W(9), .PRE_TC(TC)) u_dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .status(status),
    .count(count), .rst_req(rst_req)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_cnt(logic [7:0] d, output int at);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = d;
    @(negedge clk); cnt_wr = 1'b0; at = cyc;
  endtask

  task automatic expect_req(int at);
    exp_q.push_back(at);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare reset-request pulses against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rst_req) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          checks++;
          void'(exp_q.pop_front());
          chk("R9 state at request", {8'h0, status, count}, 0);
        end else begin
          chk("R4 unexpected reset request", cyc, exp_q.size() > 0 ? exp_q[0] : -1);
        end
      end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        chk("R4 missed reset request", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    int l1, l2, x;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 status", status, 8'h00);
    chk("R1 count", count, 8'h00);
    chk("R1 rst_req", rst_req, 0);

    wr_cnt(8'h40, l1);
    chk("R7 ignored write count", count, 8'h00);
    chk("R7 ignored write status", status, 8'h00);

    wr_ctrl(8'h01);
    chk("R2 permit visible", status, 8'h01);
    wr_cnt(8'h03, l1);
    chk("R5 permit self-clear", status, 8'h00);
    chk("R3 loaded while disarmed", count, 8'h03);
    idle(20);
    chk("R3 hold while disarmed", count, 8'h03);

    wr_ctrl(8'h03);
    wr_cnt(8'h03, l1);
    expect_req(l1 + 3 * P);
    wait (cyc == l1 + P);
    @(negedge clk);
    chk("R3 first decrement", count, 8'h02);
    wr_ctrl(8'h00);
    chk("R2 control write cannot disarm", status, 8'h02);
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk("R9 pulse ended", rst_req, 0);
    chk("R9 disarmed after request", status, 8'h00);

    wr_ctrl(8'h03);
    wr_cnt(8'h02, l1);
    wait (cyc == l1 + 12);
    wr_ctrl(8'h01);
    wr_cnt(8'h02, l2);
    expect_req(l2 + 2 * P);
    wr_cnt(8'h01, x);
    chk("R7 ignored write while armed", count, 8'h02);
    wait (exp_q.size() == 0);
    chk("R8 reload restarted interval", cyc - l2 >= 2 * P ? 1 : 0, 1);

    wr_ctrl(8'h03);
    wr_cnt(8'h05, l1);
    wr_ctrl(8'h01);
    wr_cnt(8'h00, l2);
    chk("R6 disarm status", status, 8'h00);
    chk("R6 disarm count", count, 8'h00);
    idle(100);

    wr_ctrl(8'h03);
    wr_cnt(8'hFF, l1);
    expect_req(l1 + 255 * P);
    wait (exp_q.size() == 0);
    x = cyc;
    wr_ctrl(8'h02);
    expect_req(x + P);
    wait (exp_q.size() == 0);
    idle(3);

    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule